// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds the six 8-bit configuration bytes of a clock generator and presents them on a parallel bus for the output-enable and frequency-select logic. A host writes the bytes as a single block transfer. It sends the write address, then two bytes that are acknowledged and thrown away, then data bytes that go to register 0, register 1 and onward. No register address is carried on the wire, so every write starts again at register 0. A STOP may end the transfer after any whole byte.

Read-back uses a block-read style transfer. After the read address the slave first returns the number of registers and then the registers from 0 upward, MSB first, for as long as the host acknowledges. The clock and data lines are brought into the system clock domain through a two-flop filter. START and STOP are taken from data edges while the clock is high. The bus is open-drain: the block only ever pulls data low, through an output-enable pin. Clock stretching and arbitration are not part of this block.

Top module: `cfgslv_smbus`

## Requirements
- R1: After reset, register 0 is 0x0F, register 1 is 0xFF, register 2 is 0xFE and registers 3 to 5 are 0x00. Register k appears on `cfg_o[8k+7:8k]`.
- R2: The 8-bit addresses 0xD2 (write) and 0xD3 (read) are acknowledged. An acknowledge is SDA held low for the whole ninth SCL high phase.
- R3: Any other address is not acknowledged, and the rest of that transfer has no effect on the registers.
- R4: In a write, the first two bytes after the address are acknowledged, and their values are not stored.
- R5: The data bytes of a write are stored in register 0, register 1 and upward in order. Each one is acknowledged and then shows on `cfg_o`.
- R6: If the host sends STOP after any whole byte, the registers already written keep their new values and all other registers are unchanged.
- R7: Data bytes beyond the sixth register are acknowledged and discarded.
- R8: A read returns the register count (6) first, then register 0 onward, each byte MSB first.
- R9: A read that runs past the last register returns 0x00.
- R10: A host NACK or a STOP makes the slave release SDA and go idle, and the next START is accepted normally.
- R11: A repeated START returns the slave to the address phase, and the register index starts again at 0.
- R12: The slave changes its SDA drive only after an SCL falling edge, a START or a STOP, so the drive is steady while SCL is high.
- R13: `cfg_o` changes only when a data byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples the bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 48 | Register image, register k in bits 8k+7..8k |

## Verification
The write path is tried with three kinds of transfer: a complete block with one byte too many, a block cut short by STOP, and transfers to wrong addresses. These tell apart correct storage order, early termination and address filtering. Reads are tried to the end of the register set and beyond it, and also stopped early by a NACK after the count byte, which separates count framing, end-of-data padding and release on NACK. Repeated STARTs placed in the middle of a write and between a write and a read show that the sequencer goes back to the address phase. A port sample taken after the discarded header bytes, and before any data byte, shows that they never reach the registers.

// File: rtl/cfgslv_pkg.sv
// Shared definitions for the serial configuration slave.
// Holds the bus sequencer state type and the power-on value of each register.
package cfgslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, SDA released
        ST_RX,     // shifting a byte in from the host
        ST_RACK,   // driving the acknowledge for a received byte
        ST_TX,     // shifting a byte out to the host
        ST_TACK    // sampling the host acknowledge
    } bus_state_t;

    // Power-on value of register k.
    function automatic logic [7:0] default_byte(input int k);
        case (k)
            0:       return 8'h0F;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgslv_line_sync.sv
// Brings one bus line into the clk domain through a flop chain.
// Also gives the previous synchronised value, for edge detection.
// Assumes: STAGES >= 2; the line idles high, so reset loads ones.
module cfgslv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic line_prev_o
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // Shift the raw line through the chain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], line_i};
            prev <= pipe[STAGES-1];
        end
    end

    assign line_o      = pipe[STAGES-1];
    assign line_prev_o = prev;
endmodule

// File: rtl/cfgslv_regfile.sv
// Configuration register bank with a single write port and a read mux.
// Assumes: at most one write per cycle; selects at or above NREG write nothing and read zero.
module cfgslv_regfile
    import cfgslv_pkg::*;
#(
    parameter int NREG  = 6,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] image_o
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load the power-on value on reset; otherwise take a write aimed at this byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= default_byte(g);
            else if (wr_en && wr_sel == SEL_W'(g))
                regs[g] <= wr_data;
        end
        assign image_o[g*8 +: 8] = regs[g];
    end

    // Read mux; a select past the last register gives zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_sel == SEL_W'(i)) rd_data = regs[i];
    end
endmodule

// File: rtl/cfgslv_smbus.sv
// Two-wire slave for block writes and block reads of the configuration bytes.
// Write: address, two ignored bytes, then data to register 0 upward.
// Read: register count, then register 0 upward, until the host NACKs.
// Assumes: SCL is slow next to clk (each phase lasts many clk cycles);
// no clock stretching; SDA is open-drain and this block only pulls it low.
module cfgslv_smbus
    import cfgslv_pkg::*;
#(
    parameter int         NREG        = 6,
    parameter logic [6:0] DEV_ADDR7   = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int               IDX_W   = $clog2(NREG + 3);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NREG + 2);

    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_state_t       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg, txsh, tx_byte, rd_data;
    logic             addr_phase, rw, host_nack, sda_oe;
    logic [IDX_W-1:0] byte_idx, wr_sel, rd_sel;
    logic             byte_done, addr_hit, wr_en;

    cfgslv_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_s), .line_prev_o(scl_p));
    cfgslv_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_s), .line_prev_o(sda_p));

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

    assign byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR7);
    // Index 0 and 1 are the ignored header bytes; data starts at index 2.
    assign wr_en  = byte_done && !addr_phase && (byte_idx >= IDX_W'(2)) && (byte_idx < IDX_MAX);
    assign wr_sel = byte_idx - IDX_W'(2);
    assign rd_sel = byte_idx - IDX_W'(1);
    // Read stream: index 0 is the count, then the registers, then zero padding.
    assign tx_byte = (byte_idx == '0)            ? 8'(NREG) :
                     (byte_idx <= IDX_W'(NREG))  ? rd_data  : 8'h00;

    cfgslv_regfile #(.NREG(NREG), .SEL_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(shreg),
        .rd_sel(rd_sel), .rd_data(rd_data), .image_o(cfg_o));

    // Bus sequencer: byte framing, acknowledge, transmit shifting and index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txsh       <= '0;
            addr_phase <= 1'b1;
            rw         <= 1'b0;
            host_nack  <= 1'b0;
            sda_oe     <= 1'b0;
            byte_idx   <= '0;
        end else if (start_det) begin
            state      <= ST_RX;
            addr_phase <= 1'b1;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            sda_oe     <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (addr_phase) begin
                            if (addr_hit) begin
                                sda_oe     <= 1'b1;
                                rw         <= shreg[0];
                                addr_phase <= 1'b0;
                                byte_idx   <= '0;
                                state      <= ST_RACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_RACK;
                            if (byte_idx != IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            sda_oe  <= ~tx_byte[7];
                            txsh    <= {tx_byte[6:0], 1'b0};
                            bit_cnt <= '0;
                            if (byte_idx != IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
                            state   <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TACK;
                        end else begin
                            sda_oe  <= ~txsh[7];
                            txsh    <= {txsh[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) host_nack <= sda_s;
                    if (scl_fall) begin
                        if (host_nack) begin
                            state <= ST_IDLE;
                        end else begin
                            sda_oe  <= ~tx_byte[7];
                            txsh    <= {tx_byte[6:0], 1'b0};
                            bit_cnt <= '0;
                            if (byte_idx != IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
                            state   <= ST_TX;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = sda_oe;
endmodule

// File: rtl/cfgslv_sva.sv
// Property checker for cfgslv_smbus, attached through bind.
// Watches the register image, the SDA drive and the internal write strobe.
module cfgslv_sva
    import cfgslv_pkg::*;
#(
    parameter int NREG = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NREG*8-1:0]        cfg_o,
    input logic                     sda_oe,
    input logic                     scl_fall,
    input logic                     start_det,
    input logic                     stop_det,
    input logic                     wr_en,
    input logic [$clog2(NREG+3)-1:0] wr_sel
);
    logic [NREG*8-1:0] dflt;
    logic              rst_q = 1'b0;

    // Expected power-on image, built from the per-register defaults.
    always_comb begin
        for (int k = 0; k < NREG; k++) dflt[k*8 +: 8] = default_byte(k);
    end

    // On the first edge after reset release, the image must equal the defaults.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (rst_n && !rst_q)
            assert_reset_image_R1: assert (cfg_o == dflt)
                else $error("reset image wrong");
    end

    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_sel < ($clog2(NREG+3))'(NREG)));

    assert_drive_after_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_image_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));
endmodule

bind cfgslv_smbus cfgslv_sva #(.NREG(NREG)) sva_i (
    .clk(clk), .rst_n(rst_n), .cfg_o(cfg_o), .sda_oe(sda_oe_o),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_sel(wr_sel));

// File: tb/cfgslv_smbus_tb_top.sv
// Scoreboard bench: driver tasks push expected values, a monitor compares them with observations.
module cfgslv_smbus_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;
    localparam int NREG       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg;

    assign sda_line = ~(host_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgslv_smbus dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .cfg_o(cfg));

    typedef struct { logic [47:0] v; string tag; } item_t;
    item_t       exp_q[$];
    logic [47:0] act_q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [7:0] model [NREG];

    function automatic logic [47:0] image();
        logic [47:0] r = '0;
        for (int k = 0; k < NREG; k++) r[k*8 +: 8] = model[k];
        return r;
    endfunction

    task automatic expect_val(input logic [47:0] e, input string tag, input logic [47:0] a);
        item_t it;
        it.v = e; it.tag = tag;
        exp_q.push_back(it);
        act_q.push_back(a);
    endtask

    // Monitor: pop each observation and compare it with the matching expectation.
    initial forever begin
        logic [47:0] a;
        item_t e;
        wait (act_q.size() > 0);
        a = act_q.pop_front();
        n_checks++;
        if (exp_q.size() == 0) begin
            n_errors++;
            $display("FAIL scoreboard: actual %h with no expected item", a);
        end else begin
            e = exp_q.pop_front();
            if (a !== e.v) begin
                n_errors++;
                $display("FAIL %s: actual %h expected %h", e.tag, a, e.v);
            end
        end
    end

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; wait_half();
        scl = 1'b1;      wait_half();
        host_low = 1'b1; wait_half();
        scl = 1'b0;      wait_half();
    endtask

    task automatic bus_stop();
        host_low = 1'b1; wait_half();
        scl = 1'b1;      wait_half();
        host_low = 1'b0; wait_half();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack, output logic steady);
        logic early;
        for (int i = 7; i >= 0; i--) begin
            host_low = ~b[i]; wait_half();
            scl = 1'b1;       wait_half();
            scl = 1'b0;
        end
        host_low = 1'b0; wait_half();
        scl = 1'b1;
        repeat (2) @(negedge clk);
        early = sda_line;
        repeat (HALF-2) @(negedge clk);
        ack = ~sda_line;
        steady = (early == sda_line);
        scl = 1'b0;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        host_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_half();
            scl = 1'b1;
            repeat (HALF/2) @(negedge clk);
            b[i] = sda_line;
            repeat (HALF/2) @(negedge clk);
            scl = 1'b0;
        end
        host_low = ~nack; wait_half();
        scl = 1'b1;       wait_half();
        scl = 1'b0;
        host_low = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
        logic ack, st;
        write_byte(b, ack, st);
        expect_val(48'(exp_ack), tag, 48'(ack));
    endtask

    task automatic recv_chk(input logic nack, input logic [7:0] e, input string tag);
        logic [7:0] b;
        read_byte(nack, b);
        expect_val(48'(e), tag, 48'(b));
    endtask

    task automatic cfg_chk(input string tag);
        @(negedge clk);
        expect_val(image(), tag, cfg);
    endtask

    // Watchdog: an overlong run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1..: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Driver sequence.
    initial begin
        logic ack, st;
        for (int k = 0; k < NREG; k++) model[k] = (k == 0) ? 8'h0F : (k == 1) ? 8'hFF : (k == 2) ? 8'hFE : 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        cfg_chk("R1 reset image");

        // Full block write with one surplus byte.
        bus_start();
        write_byte(8'hD2, ack, st);
        expect_val(48'd1, "R2 write address ack", 48'(ack));
        expect_val(48'd1, "R12 ack steady while SCL high", 48'(st));
        send_chk(8'hAA, 1'b1, "R4 command byte ack");
        send_chk(8'h55, 1'b1, "R4 count byte ack");
        for (int k = 0; k < NREG; k++) begin
            model[k] = 8'h11 * 8'(k + 1);
            send_chk(model[k], 1'b1, "R5 data byte ack");
        end
        send_chk(8'h77, 1'b1, "R7 surplus byte ack");
        bus_stop();
        cfg_chk("R4 R5 R7 image after full write");

        // Header bytes must not reach the registers.
        bus_start();
        send_chk(8'hD2, 1'b1, "R2 write address ack");
        send_chk(8'hFF, 1'b1, "R4 command ack");
        send_chk(8'hFF, 1'b1, "R4 count ack");
        cfg_chk("R13 image unchanged after header bytes");
        bus_stop();

        // Write cut short by STOP.
        bus_start();
        send_chk(8'hD2, 1'b1, "R2 write address ack");
        send_chk(8'h00, 1'b1, "R4 command ack");
        send_chk(8'h00, 1'b1, "R4 count ack");
        send_chk(8'hA1, 1'b1, "R6 data ack"); model[0] = 8'hA1;
        send_chk(8'hB2, 1'b1, "R6 data ack"); model[1] = 8'hB2;
        bus_stop();
        cfg_chk("R6 partial write");

        // Foreign addresses.
        bus_start();
        send_chk(8'hA0, 1'b0, "R3 foreign address nack");
        bus_stop();
        bus_start();
        send_chk(8'hD4, 1'b0, "R3 near address nack");
        send_chk(8'h00, 1'b0, "R3 ignored byte");
        send_chk(8'h00, 1'b0, "R3 ignored byte");
        send_chk(8'hEE, 1'b0, "R3 ignored data");
        bus_stop();
        cfg_chk("R3 image unchanged");

        // Full read with one byte past the end.
        bus_start();
        send_chk(8'hD3, 1'b1, "R2 read address ack");
        recv_chk(1'b0, 8'h06, "R8 count byte");
        for (int k = 0; k < NREG; k++) recv_chk(1'b0, model[k], "R8 register byte");
        recv_chk(1'b1, 8'h00, "R9 byte past end");
        bus_stop();
        cfg_chk("R13 image unchanged by read");

        // Early NACK then a normal write.
        bus_start();
        send_chk(8'hD3, 1'b1, "R2 read address ack");
        recv_chk(1'b1, 8'h06, "R10 count then nack");
        bus_stop();
        bus_start();
        send_chk(8'hD2, 1'b1, "R10 address ack after nack");
        send_chk(8'h00, 1'b1, "R4 command ack");
        send_chk(8'h00, 1'b1, "R4 count ack");
        send_chk(8'h5A, 1'b1, "R10 data ack"); model[0] = 8'h5A;
        bus_stop();
        cfg_chk("R10 write after nacked read");

        // Repeated START inside a write.
        bus_start();
        send_chk(8'hD2, 1'b1, "R2 write address ack");
        send_chk(8'h00, 1'b1, "R4 command ack");
        send_chk(8'h00, 1'b1, "R4 count ack");
        send_chk(8'hC3, 1'b1, "R11 data ack");
        bus_start();
        send_chk(8'hD2, 1'b1, "R11 address ack after repeated start");
        send_chk(8'h00, 1'b1, "R4 command ack");
        send_chk(8'h00, 1'b1, "R4 count ack");
        send_chk(8'h3C, 1'b1, "R11 data ack"); model[0] = 8'h3C;
        send_chk(8'h7E, 1'b1, "R11 data ack"); model[1] = 8'h7E;
        bus_stop();
        cfg_chk("R11 index restarts at zero");

        // Repeated START from write header into a read.
        bus_start();
        send_chk(8'hD2, 1'b1, "R2 write address ack");
        send_chk(8'h00, 1'b1, "R4 command ack");
        bus_start();
        send_chk(8'hD3, 1'b1, "R11 read address after repeated start");
        recv_chk(1'b0, 8'h06, "R11 count byte");
        recv_chk(1'b1, model[0], "R11 register 0");
        bus_stop();
        cfg_chk("R13 image after mixed transfer");

        wait (act_q.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule